// File: doc/BRIEF.md
# Multi-Line Configurable Edge Accumulator

This block keeps a single running count fed by several independent signal lines. Every line first passes through a two-stage synchronizer. Each line then has its own trigger setting, which picks the transitions that count: none, rising only, falling only, or either direction. A global direction bit decides whether a trigger adds or subtracts. When several lines trigger in the same clock cycle, their contributions are combined and the net sum is applied in one update.

Lines 0 and 1 can also be handed to a quadrature decoder, with line 0 as channel A and line 1 as channel B. The decoder offers single, double and quadruple resolution. In that case the sign of each step comes from the phase between the two channels, and lines 2 and up keep their own trigger settings. A synchronous load strobe overwrites the count with a given value.

Top module: `edge_accum`

## Requirements
- R1: An input line change that is applied before rising edge k alters `value` only at edge k+2. It is visible after that edge and not before it. This is the result of two synchronizer flops followed by the edge-detection register.
- R2: The trigger setting for line i sits in `line_mode[2i+1:2i]`, coded as 0 = none, 1 = rising, 2 = falling, 3 = both. A transition that the setting does not select leaves `value` unchanged.
- R3: With quadrature decoding off, `count_down` = 0 makes each trigger add 1 and `count_down` = 1 makes each trigger subtract 1.
- R4: Triggers on several lines in the same cycle change `value` by their net sum in a single update.
- R5: `value` wraps modulo 2^CNT_W in both directions.
- R6: When `load` is high at a clock edge, `value` takes `load_val` at that edge, and any triggers in that cycle are discarded.
- R7: With `quad_sel` = 1 (x1), only A transitions made while B is low count: A rising adds 1 and A falling subtracts 1.
- R8: With `quad_sel` = 2 (x2), every A transition counts. A rising adds 1 when B is low and subtracts 1 when B is high. A falling adds 1 when B is high and subtracts 1 when B is low.
- R9: With `quad_sel` = 3 (x4), every A transition counts as in R8. B rising adds 1 when A is high and subtracts 1 when A is low. B falling adds 1 when A is low and subtracts 1 when A is high.
- R10: When quadrature decoding is on (`quad_sel` not 0), the trigger settings of lines 0 and 1 and the `count_down` bit have no effect on the A/B steps. Lines 2 and up keep counting by their own settings.
- R11: A synchronous active-low reset clears `value` and the synchronizer state to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | NUM_LINES | Asynchronous signal lines |
| line_mode | input | 2*NUM_LINES | Per-line trigger settings, 2 bits each |
| count_down | input | 1 | 0 = triggers add, 1 = triggers subtract |
| quad_sel | input | 2 | 0 off, 1 x1, 2 x2, 3 x4 decode on lines 0/1 |
| load | input | 1 | Synchronous load strobe |
| load_val | input | CNT_W | Value written on load |
| value | output | CNT_W | Accumulated count |

## Verification
The bench builds the block with its defaults, NUM_LINES = 4 and CNT_W = 16. Four lines are enough to see a net step of ±4 in one update, and to mix quadrature steps on lines 0/1 with a plain trigger on line 2 in the same cycle. A 16-bit count makes both wrap directions (0xFFFF to 0 and 0 to 0xFFFF) reachable with a single load and a single edge. It also lets the bench time the load against a trigger to the exact cycle, and measure the synchronizer latency edge by edge.

// File: rtl/edge_accum_pkg.sv
// Shared encodings for the edge accumulator.
package edge_accum_pkg;
    typedef enum logic [1:0] {
        TRIG_NONE = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_BOTH = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        QUAD_OFF = 2'd0,
        QUAD_X1  = 2'd1,
        QUAD_X2  = 2'd2,
        QUAD_X4  = 2'd3
    } quad_sel_e;
endpackage

// File: rtl/edge_accum_sync.sv
// Two-flop synchronizer plus a history register for every line.
// Assumes: raw lines are asynchronous; cur/prv are the present and
// previous synchronized levels, so an edge is cur != prv.
module edge_accum_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta;

    // Shift lines through two sync stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            cur  <= '0;
            prv  <= '0;
        end else begin
            meta <= raw;
            cur  <= meta;
            prv  <= cur;
        end
    end

    // Checker-only age counter: cycles since reset, saturating at 3.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (cur == $past(raw, 2)));
endmodule

// File: rtl/edge_accum_line.sv
// Per-line trigger: turns one synchronized line into a step of -1/0/+1.
// Assumes: cur/prv are synchronized levels one cycle apart.
module edge_accum_line
    import edge_accum_pkg::*;
(
    input  logic              cur,
    input  logic              prv,
    input  logic [1:0]        mode,
    input  logic              down,
    output logic signed [1:0] step
);
    logic rise, fall, hit;

    // Select the transitions the mode asks for and sign them by direction.
    always_comb begin
        rise = cur & ~prv;
        fall = ~cur & prv;
        case (trig_mode_e'(mode))
            TRIG_RISE: hit = rise;
            TRIG_FALL: hit = fall;
            TRIG_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        if (!hit)      step = 2'sd0;
        else if (down) step = -2'sd1;
        else           step = 2'sd1;
    end
endmodule

// File: rtl/edge_accum_quad.sv
// Quadrature decoder for channels A (line 0) and B (line 1).
// Assumes: forward means A leads B; each edge is judged against the
// other channel's previous synchronized level.
module edge_accum_quad
    import edge_accum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_cur,
    input  logic              a_prv,
    input  logic              b_cur,
    input  logic              b_prv,
    input  logic [1:0]        sel,
    output logic signed [1:0] a_step,
    output logic signed [1:0] b_step
);
    logic a_rise, a_fall, b_rise, b_fall;

    // Derive A and B steps for the selected resolution.
    always_comb begin
        a_rise = a_cur & ~a_prv;
        a_fall = ~a_cur & a_prv;
        b_rise = b_cur & ~b_prv;
        b_fall = ~b_cur & b_prv;
        a_step = 2'sd0;
        b_step = 2'sd0;
        case (quad_sel_e'(sel))
            QUAD_X1: begin
                if (a_rise && !b_prv)      a_step = 2'sd1;
                else if (a_fall && !b_prv) a_step = -2'sd1;
            end
            QUAD_X2, QUAD_X4: begin
                if (a_rise)      a_step = b_prv ? -2'sd1 : 2'sd1;
                else if (a_fall) a_step = b_prv ? 2'sd1 : -2'sd1;
                if (quad_sel_e'(sel) == QUAD_X4) begin
                    if (b_rise)      b_step = a_prv ? 2'sd1 : -2'sd1;
                    else if (b_fall) b_step = a_prv ? -2'sd1 : 2'sd1;
                end
            end
            default: ;
        endcase
    end

    assert_x1_b_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == 2'd1) && a_cur && !a_prv && b_prv) |-> (a_step == 2'sd0));
    assert_x1_b_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == 2'd1) && (b_cur != b_prv)) |-> (b_step == 2'sd0 && (a_cur == a_prv || !b_prv || a_step == 2'sd0)));
endmodule

// File: rtl/edge_accum.sv
// Multi-line edge accumulator top.
// Assumes: NUM_LINES >= 2, CNT_W > SUM_W; lines 0/1 double as A/B.
module edge_accum
    import edge_accum_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int CNT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   line_in,
    input  logic [2*NUM_LINES-1:0] line_mode,
    input  logic                   count_down,
    input  logic [1:0]             quad_sel,
    input  logic                   load,
    input  logic [CNT_W-1:0]       load_val,
    output logic [CNT_W-1:0]       value
);
    localparam int SUM_W = $clog2(NUM_LINES + 1) + 1;

    logic [NUM_LINES-1:0] s_cur, s_prv;
    logic signed [1:0]    step [NUM_LINES];
    logic signed [1:0]    qa_step, qb_step;
    logic signed [SUM_W-1:0] net;
    logic                 quad_on;
    logic [CNT_W-1:0]     value_q;

    edge_accum_sync #(.W(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(line_in), .cur(s_cur), .prv(s_prv)
    );

    edge_accum_quad u_quad (
        .clk(clk), .rst_n(rst_n),
        .a_cur(s_cur[0]), .a_prv(s_prv[0]),
        .b_cur(s_cur[1]), .b_prv(s_prv[1]),
        .sel(quad_sel), .a_step(qa_step), .b_step(qb_step)
    );

    assign quad_on = (quad_sel_e'(quad_sel) != QUAD_OFF);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic signed [1:0] l_step;
        edge_accum_line u_line (
            .cur(s_cur[i]), .prv(s_prv[i]),
            .mode(line_mode[2*i +: 2]), .down(count_down), .step(l_step)
        );
        if (i == 0) begin : g_a
            assign step[i] = quad_on ? qa_step : l_step;
        end else if (i == 1) begin : g_b
            assign step[i] = quad_on ? qb_step : l_step;
        end else begin : g_plain
            assign step[i] = l_step;
        end
    end

    // Add up the signed steps of all lines.
    always_comb begin
        net = '0;
        for (int i = 0; i < NUM_LINES; i++) net = net + SUM_W'(step[i]);
    end

    // Accumulate the net step, with load taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    value_q <= '0;
        else if (load) value_q <= load_val;
        else           value_q <= value_q + {{(CNT_W-SUM_W){net[SUM_W-1]}}, net};
    end

    assign value = value_q;

    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (value == '0));
    assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (value == $past(load_val)));
    assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((CNT_W'(value - $past(value)) <= CNT_W'(NUM_LINES)) ||
                   (CNT_W'($past(value) - value) <= CNT_W'(NUM_LINES))));
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (s_cur == s_prv)) |=> $stable(value));
endmodule

// File: tb/edge_accum_bench.sv
`timescale 1ns/1ps
module edge_accum_bench;
    localparam int NL = 4;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] line_in = '0;
    logic [2*NL-1:0] line_mode = '0;
    logic          count_down = 1'b0;
    logic [1:0]    quad_sel = 2'd0;
    logic          load = 1'b0;
    logic [CW-1:0] load_val = '0;
    logic [CW-1:0] value;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_accum #(.NUM_LINES(NL), .CNT_W(CW)) u_edge_accum (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_mode(line_mode),
        .count_down(count_down), .quad_sel(quad_sel), .load(load),
        .load_val(load_val), .value(value)
    );

    typedef struct packed {
        logic [7:0]        mode;
        logic [1:0]        quad;
        logic              down;
        logic [3:0]        st;
        logic [3:0]        en;
        logic signed [3:0] dl;
        logic [3:0]        rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{8'h01, 2'd0, 1'b0, 4'b0000, 4'b0001,  4'sd1, 4'd2},  // R2 rise counts
        '{8'h01, 2'd0, 1'b0, 4'b0001, 4'b0000,  4'sd0, 4'd2},  // R2 fall ignored
        '{8'h08, 2'd0, 1'b0, 4'b0010, 4'b0000,  4'sd1, 4'd2},  // R2 fall mode
        '{8'h30, 2'd0, 1'b1, 4'b0000, 4'b0100, -4'sd1, 4'd3},  // R3 down
        '{8'hFF, 2'd0, 1'b0, 4'b0000, 4'b1111,  4'sd4, 4'd4},  // R4 net +4
        '{8'hFF, 2'd0, 1'b1, 4'b1111, 4'b0000, -4'sd4, 4'd4},  // R4 net -4
        '{8'hC9, 2'd0, 1'b0, 4'b0110, 4'b1011,  4'sd2, 4'd2},  // R2 mixed modes
        '{8'h00, 2'd1, 1'b0, 4'b0000, 4'b0001,  4'sd1, 4'd7},  // R7 A rise, B low
        '{8'h00, 2'd1, 1'b0, 4'b0001, 4'b0000, -4'sd1, 4'd7},  // R7 A fall, B low
        '{8'h00, 2'd1, 1'b0, 4'b0010, 4'b0011,  4'sd0, 4'd7},  // R7 A rise, B high
        '{8'h00, 2'd2, 1'b0, 4'b0010, 4'b0011, -4'sd1, 4'd8},  // R8 A rise, B high
        '{8'h00, 2'd2, 1'b0, 4'b0011, 4'b0010,  4'sd1, 4'd8},  // R8 A fall, B high
        '{8'h00, 2'd3, 1'b0, 4'b0001, 4'b0011,  4'sd1, 4'd9},  // R9 B rise, A high
        '{8'h00, 2'd3, 1'b0, 4'b0011, 4'b0001, -4'sd1, 4'd9},  // R9 B fall, A high
        '{8'h00, 2'd3, 1'b0, 4'b0000, 4'b0010, -4'sd1, 4'd9},  // R9 B rise, A low
        '{8'h00, 2'd3, 1'b1, 4'b0001, 4'b0011,  4'sd1, 4'd10}, // R10 down ignored
        '{8'h30, 2'd3, 1'b0, 4'b0001, 4'b0111,  4'sd2, 4'd10}, // R10 line 2 still counts
        '{8'h03, 2'd1, 1'b0, 4'b0010, 4'b0011,  4'sd0, 4'd10}  // R10 line 0 mode ignored
    };

    task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: value=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_load(input logic [CW-1:0] v);
        @(negedge clk);
        load = 1'b1;
        load_val = v;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic quiet();
        line_mode = '0;
        quad_sel = 2'd0;
        count_down = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset value", value, 16'h0000);
        rst_n = 1'b1;
        settle();
        chk("R11 after reset release", value, 16'h0000);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            logic [CW-1:0] exp;
            quiet();
            line_in = VEC[v].st;
            settle();
            do_load(16'h0100);
            line_mode = VEC[v].mode;
            quad_sel = VEC[v].quad;
            count_down = VEC[v].down;
            @(negedge clk);
            line_in = VEC[v].en;
            settle();
            exp = 16'h0100 + {{(CW-4){VEC[v].dl[3]}}, VEC[v].dl};
            chk($sformatf("R%0d vector %0d", VEC[v].rq, v), value, exp);
        end

        // R1: latency of two sync flops plus edge register.
        quiet();
        line_in = '0;
        settle();
        do_load(16'h0010);
        line_mode = 8'h01;
        @(negedge clk);
        line_in = 4'b0001;
        @(negedge clk);
        chk("R1 after first edge", value, 16'h0010);
        @(negedge clk);
        chk("R1 after second edge", value, 16'h0010);
        @(negedge clk);
        chk("R1 after third edge", value, 16'h0011);

        // R5: wrap upward and downward.
        quiet();
        line_in = '0;
        settle();
        do_load(16'hFFFF);
        line_mode = 8'h01;
        line_in = 4'b0001;
        settle();
        chk("R5 wrap up", value, 16'h0000);
        quiet();
        line_in = '0;
        settle();
        do_load(16'h0000);
        line_mode = 8'h01;
        count_down = 1'b1;
        line_in = 4'b0001;
        settle();
        chk("R5 wrap down", value, 16'hFFFF);

        // R6: load in the same cycle as a trigger wins.
        quiet();
        line_in = '0;
        settle();
        do_load(16'h0200);
        line_mode = 8'h01;
        @(negedge clk);
        line_in = 4'b0001;
        @(negedge clk);
        @(negedge clk);
        load = 1'b1;
        load_val = 16'h0777;
        @(negedge clk);
        load = 1'b0;
        chk("R6 load over trigger", value, 16'h0777);
        settle();
        chk("R6 trigger discarded", value, 16'h0777);

        // R9: full forward x4 cycle, then full reverse.
        quiet();
        line_in = '0;
        settle();
        do_load(16'h0040);
        quad_sel = 2'd3;
        line_in = 4'b0001; settle();
        line_in = 4'b0011; settle();
        line_in = 4'b0010; settle();
        line_in = 4'b0000; settle();
        chk("R9 forward cycle", value, 16'h0044);
        line_in = 4'b0010; settle();
        line_in = 4'b0011; settle();
        line_in = 4'b0001; settle();
        line_in = 4'b0000; settle();
        chk("R9 reverse cycle", value, 16'h0040);

        // R11: reset in mid-run.
        quiet();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 mid-run reset", value, 16'h0000);
        rst_n = 1'b1;
        settle();
        chk("R11 hold after reset", value, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: value=%h expected=run complete", value);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule